// File: doc/BRIEF.md
# UART Register Bank and Interrupt Unit

This block is the host-facing side of a simple serial port. It decodes eight 32-bit registers at word offsets, so the byte address is shifted right by two. It latches received bytes from a byte-stream source into a single holding register and flags an overrun when a new byte lands on one that has not been read. Bytes that the host writes go out on a transmit byte stream. Error strobes from an external bit-level receiver are collected into sticky line-status bits. A modem-status byte is sampled from an input every cycle.

One interrupt line is driven from a fixed-priority encoder. An identification code in its own register tells the host which source is being served. The control registers are write-only: their values go out on ports to the baud generator and line logic, which sit outside this block, and reads of them return zero. This block does no bit timing, no parity or framing checking and no buffering.

Top module: `uart_regbank`

## Requirements
- R1: After reset, line status (offset 5) reads 0x60, identification (offset 2) reads 0x1, irq is 0, rx_ready is 1, tx_valid is 0 and the control outputs are 0.
- R2: A cycle with rx_valid high stores rx_byte in the holding register and sets data ready (line status bit 0). rx_ready is the inverse of data ready.
- R3: A read of offset 0 returns the held byte and clears data ready. If a byte arrives in the same cycle as that read, data ready stays set and no overrun is flagged.
- R4: A byte that arrives while data ready is set and no data read happens in the same cycle sets overrun (bit 1). The new byte replaces the held one.
- R5: Strobes on err_parity, err_frame and err_break set line status bits 2, 3 and 4. A read of offset 5 clears bits 1 to 4. A strobe in the same cycle as that read wins.
- R6: Interrupt enable bits are 0 = receive, 1 = transmit-empty, 2 = line error, 3 = modem. Sources are ranked from highest to lowest, with these identification codes:
  - any of bits 1 to 4 set with enable bit 2 gives 0b110;
  - data ready with enable bit 0 gives 0b100;
  - transmit holding empty (bit 5, always set) with enable bit 1 gives 0b010;
  - any of modem status bits 3:0 with enable bit 3 gives 0b000.
- R7: When no enabled source is active, identification reads 0b001 and irq is 0. Otherwise irq is 1. Both follow register state in the cycle after any change.
- R8: Offsets 1, 3, 4 and 7 (interrupt enable, line control, modem control, divisor) take writes and read back as zero. Their stored values appear on ier_out, line_ctrl, modem_ctrl and divisor.
- R9: Writes to offsets 2, 5 and 6 change nothing.
- R10: A write to offset 0 gives a one-cycle tx_valid pulse in the next cycle, with tx_byte equal to the low byte written.
- R11: Offset 6 reads the value of modem_in registered on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, combinational from current state |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | DATA_W | Received byte |
| rx_ready | output | 1 | High while the holding register is empty |
| err_parity | input | 1 | Parity error strobe |
| err_frame | input | 1 | Framing error strobe |
| err_break | input | 1 | Break strobe |
| modem_in | input | 8 | Modem status inputs |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | DATA_W | Transmit byte |
| ier_out | output | 4 | Stored interrupt enables |
| line_ctrl | output | 8 | Stored line control |
| modem_ctrl | output | 8 | Stored modem control |
| divisor | output | DIV_W | Stored divisor |
| irq | output | 1 | Interrupt request |

## Verification
The bench walks the interrupt ranking with several sources active at once. It clears the higher sources one by one and checks that the identification code steps down 0b110, 0b100, 0b010. A bad priority order would show the wrong code at the first step.

It also drives a data read and a new byte in the same cycle. A design that clears data ready there would lose the byte, and one that flags overrun would report a false error. An error strobe is fired in the same cycle as a status read, where a design that lets the clear win would drop the error silently.

Writes to read-only offsets and reads of write-only offsets are checked. This catches a decoder that aliases them.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;
   typedef enum logic [2:0] {
      OFS_DATA  = 3'd0,
      OFS_IEN   = 3'd1,
      OFS_IID   = 3'd2,
      OFS_LCTL  = 3'd3,
      OFS_MCTL  = 3'd4,
      OFS_LSTAT = 3'd5,
      OFS_MSTAT = 3'd6,
      OFS_DIV   = 3'd7
   } reg_ofs_e;

   // sticky error vector order: 0 overrun, 1 parity, 2 framing, 3 break
   localparam int ERR_N = 4;

   localparam logic [2:0] ID_LINE  = 3'b110;
   localparam logic [2:0] ID_RX    = 3'b100;
   localparam logic [2:0] ID_TX    = 3'b010;
   localparam logic [2:0] ID_MODEM = 3'b000;
   localparam logic [2:0] ID_NONE  = 3'b001;
endpackage

// File: rtl/uart_rx_hold.sv
module uart_rx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] hold,
   output logic              ready_flag,
   output logic              overrun_set
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold       <= '0;
         ready_flag <= 1'b0;
      end else if (push) begin
         hold       <= push_data;
         ready_flag <= 1'b1;
      end else if (pop) begin
         ready_flag <= 1'b0;
      end
   end

   // a new byte on an unread one, unless the host takes the old byte this cycle
   assign overrun_set = push & ready_flag & ~pop;
endmodule

// File: rtl/uart_err_sticky.sv
module uart_err_sticky #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_vec,
   input  logic         clr,
   output logic [N-1:0] flags
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          flags[i] <= 1'b0;
         else if (set_vec[i]) flags[i] <= 1'b1;
         else if (clr)        flags[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_regbank_pkg::*;
(
   input  logic [3:0]       ien,
   input  logic             data_rdy,
   input  logic [ERR_N-1:0] errs,
   input  logic             thr_empty,
   input  logic [3:0]       mdm_delta,
   output logic             irq,
   output logic [2:0]       iid
);
   always_comb begin
      irq = 1'b1;
      if ((|errs) && ien[2])           iid = ID_LINE;
      else if (data_rdy && ien[0])     iid = ID_RX;
      else if (thr_empty && ien[1])    iid = ID_TX;
      else if ((|mdm_delta) && ien[3]) iid = ID_MODEM;
      else begin
         iid = ID_NONE;
         irq = 1'b0;
      end
   end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
   import uart_regbank_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int BUS_W  = 32,
   parameter int ADDR_W = 5,
   parameter int DIV_W  = 16,
   parameter bit TX_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_byte,
   output logic              rx_ready,
   input  logic              err_parity,
   input  logic              err_frame,
   input  logic              err_break,
   input  logic [7:0]        modem_in,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_byte,
   output logic [3:0]        ier_out,
   output logic [7:0]        line_ctrl,
   output logic [7:0]        modem_ctrl,
   output logic [DIV_W-1:0]  divisor,
   output logic              irq
);
   localparam int OFS_LSB = 2;
   localparam int OFS_MSB = OFS_LSB + 2;
   localparam int LSR_W   = 8;

   if (ADDR_W < OFS_MSB + 1) begin : g_bad_addr
      $error("uart_regbank: ADDR_W must cover eight word offsets");
   end
   if (BUS_W < DIV_W || BUS_W < LSR_W || BUS_W < DATA_W) begin : g_bad_bus
      $error("uart_regbank: BUS_W narrower than a register");
   end
   if (DATA_W > 8 || DATA_W < 5) begin : g_bad_data
      $error("uart_regbank: DATA_W must be 5 to 8");
   end

   // address decode
   logic     in_range;
   reg_ofs_e ofs;
   if (ADDR_W > OFS_MSB + 1) begin : g_hi_addr
      assign in_range = (bus_addr[ADDR_W-1:OFS_MSB+1] == '0);
   end else begin : g_exact_addr
      assign in_range = 1'b1;
   end
   assign ofs = reg_ofs_e'(bus_addr[OFS_MSB:OFS_LSB]);

   logic rd_stb, wr_stb;
   logic rd_data_stb, rd_lsr_stb, wr_data_stb;
   assign rd_stb      = bus_sel & ~bus_wr & in_range;
   assign wr_stb      = bus_sel &  bus_wr & in_range;
   assign rd_data_stb = rd_stb & (ofs == OFS_DATA);
   assign rd_lsr_stb  = rd_stb & (ofs == OFS_LSTAT);
   assign wr_data_stb = wr_stb & (ofs == OFS_DATA);

   // write-only control registers and modem sampling
   logic [3:0]       ier_q;
   logic [7:0]       lctl_q, mctl_q, msr_q;
   logic [DIV_W-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ier_q  <= '0;
         lctl_q <= '0;
         mctl_q <= '0;
         div_q  <= '0;
         msr_q  <= '0;
      end else begin
         msr_q <= modem_in;
         if (wr_stb) begin
            case (ofs)
               OFS_IEN:  ier_q  <= bus_wdata[3:0];
               OFS_LCTL: lctl_q <= bus_wdata[7:0];
               OFS_MCTL: mctl_q <= bus_wdata[7:0];
               OFS_DIV:  div_q  <= bus_wdata[DIV_W-1:0];
               default:  ;
            endcase
         end
      end
   end

   assign ier_out    = ier_q;
   assign line_ctrl  = lctl_q;
   assign modem_ctrl = mctl_q;
   assign divisor    = div_q;

   // receive holding register
   logic [DATA_W-1:0] hold_q;
   logic              dr_q, oe_set;

   uart_rx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (rx_valid),
      .push_data  (rx_byte),
      .pop        (rd_data_stb),
      .hold       (hold_q),
      .ready_flag (dr_q),
      .overrun_set(oe_set)
   );
   assign rx_ready = ~dr_q;

   // sticky line errors
   logic [ERR_N-1:0] err_q;

   uart_err_sticky #(.N(ERR_N)) u_err (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_vec({err_break, err_frame, err_parity, oe_set}),
      .clr    (rd_lsr_stb),
      .flags  (err_q)
   );

   // transmitter side has no buffer here: both empty bits held high
   logic [LSR_W-1:0] lsr_w;
   assign lsr_w = {1'b0, 1'b1, 1'b1, err_q, dr_q};

   // interrupt encoder
   logic [2:0] iid_w;

   uart_irq_prio u_prio (
      .ien      (ier_q),
      .data_rdy (dr_q),
      .errs     (err_q),
      .thr_empty(lsr_w[5]),
      .mdm_delta(msr_q[3:0]),
      .irq      (irq),
      .iid      (iid_w)
   );

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (rd_stb) begin
         case (ofs)
            OFS_DATA:  bus_rdata = BUS_W'(hold_q);
            OFS_IID:   bus_rdata = BUS_W'(iid_w);
            OFS_LSTAT: bus_rdata = BUS_W'(lsr_w);
            OFS_MSTAT: bus_rdata = BUS_W'(msr_q);
            default:   bus_rdata = '0;
         endcase
      end
   end

   // transmit stream, registered or pass-through
   if (TX_REG) begin : g_tx_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
         end else begin
            tx_valid <= wr_data_stb;
            if (wr_data_stb) tx_byte <= bus_wdata[DATA_W-1:0];
         end
      end
   end else begin : g_tx_comb
      assign tx_valid = wr_data_stb;
      assign tx_byte  = bus_wdata[DATA_W-1:0];
   end
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk #(
   parameter int DATA_W = 8,
   parameter int BUS_W  = 32,
   parameter bit TX_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_data_stb,
   input logic              rd_lsr_stb,
   input logic              wr_data_stb,
   input logic              rx_valid,
   input logic              err_parity,
   input logic              err_frame,
   input logic              err_break,
   input logic              dr_q,
   input logic [3:0]        err_q,
   input logic [3:0]        ier_q,
   input logic [2:0]        iid_w,
   input logic              irq,
   input logic              tx_valid,
   input logic [DATA_W-1:0] tx_byte,
   input logic [BUS_W-1:0]  bus_wdata
);
   assert_rx_sets_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> dr_q);

   assert_read_clears_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_stb && !rx_valid) |=> !dr_q);

   assert_overrun_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && dr_q && !rd_data_stb) |=> err_q[0]);

   assert_lsr_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_lsr_stb && !rx_valid && !err_parity && !err_frame && !err_break) |=> (err_q == 4'b0));

   assert_line_prio_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((|err_q) && ier_q[2]) |-> (iid_w == 3'b110));

   assert_irq_matches_id_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq == !iid_w[0]);

   if (TX_REG) begin : g_tx_chk
      assert_tx_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
         wr_data_stb |=> (tx_valid && tx_byte == $past(bus_wdata[DATA_W-1:0])));
   end
endmodule

bind uart_regbank uart_regbank_chk #(.DATA_W(DATA_W), .BUS_W(BUS_W), .TX_REG(TX_REG)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_data_stb(rd_data_stb),
   .rd_lsr_stb (rd_lsr_stb),
   .wr_data_stb(wr_data_stb),
   .rx_valid   (rx_valid),
   .err_parity (err_parity),
   .err_frame  (err_frame),
   .err_break  (err_break),
   .dr_q       (dr_q),
   .err_q      (err_q),
   .ier_q      (ier_q),
   .iid_w      (iid_w),
   .irq        (irq),
   .tx_valid   (tx_valid),
   .tx_byte    (tx_byte),
   .bus_wdata  (bus_wdata)
);

// File: tb/sim_uart_regbank.sv
module sim_uart_regbank;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 5;
   localparam int BUS_W  = 32;
   localparam int DIV_W  = 16;

   // vector kinds
   localparam bit [2:0] K_WR  = 3'd0;
   localparam bit [2:0] K_RD  = 3'd1;
   localparam bit [2:0] K_RX  = 3'd2;
   localparam bit [2:0] K_ERR = 3'd3; // data bit 0 parity, 1 frame, 2 break
   localparam bit [2:0] K_MDM = 3'd4;
   localparam bit [2:0] K_IRQ = 3'd5;

   localparam int NV = 46;
   // {req[3:0], kind, offset, data/expected}
   localparam bit [41:0] VEC [NV] = '{
      {4'd8,  K_WR,  3'd1, 32'h1},    // R8 enable receive
      {4'd7,  K_IRQ, 3'd0, 32'h0},    // R7
      {4'd2,  K_RX,  3'd0, 32'hA5},   // R2
      {4'd6,  K_IRQ, 3'd0, 32'h1},    // R6
      {4'd6,  K_RD,  3'd2, 32'h4},    // R6 receive id
      {4'd2,  K_RD,  3'd5, 32'h61},   // R2
      {4'd3,  K_RD,  3'd0, 32'hA5},   // R3
      {4'd7,  K_IRQ, 3'd0, 32'h0},    // R7
      {4'd7,  K_RD,  3'd2, 32'h1},    // R7
      {4'd4,  K_RX,  3'd0, 32'h11},   // R4
      {4'd4,  K_RX,  3'd0, 32'h22},   // R4 overrun
      {4'd6,  K_RD,  3'd2, 32'h4},    // R6 line not enabled
      {4'd6,  K_WR,  3'd1, 32'h5},    // R6
      {4'd6,  K_RD,  3'd2, 32'h6},    // R6 line id
      {4'd4,  K_RD,  3'd5, 32'h63},   // R4
      {4'd5,  K_RD,  3'd2, 32'h4},    // R5 cleared by read
      {4'd4,  K_RD,  3'd0, 32'h22},   // R4 newest byte kept
      {4'd5,  K_RD,  3'd5, 32'h60},   // R5
      {4'd6,  K_WR,  3'd1, 32'h2},    // R6
      {4'd6,  K_RD,  3'd2, 32'h2},    // R6 transmit id
      {4'd6,  K_IRQ, 3'd0, 32'h1},    // R6
      {4'd6,  K_WR,  3'd1, 32'h8},    // R6
      {4'd11, K_MDM, 3'd0, 32'h01},   // R11
      {4'd6,  K_RD,  3'd2, 32'h0},    // R6 modem id
      {4'd11, K_RD,  3'd6, 32'h01},   // R11
      {4'd11, K_MDM, 3'd0, 32'h10},   // R11
      {4'd6,  K_RD,  3'd2, 32'h1},    // R6 upper modem bits ignored
      {4'd11, K_RD,  3'd6, 32'h10},   // R11
      {4'd8,  K_RD,  3'd1, 32'h0},    // R8
      {4'd9,  K_WR,  3'd5, 32'h0},    // R9
      {4'd9,  K_WR,  3'd2, 32'h0},    // R9
      {4'd9,  K_WR,  3'd6, 32'hFF},   // R9
      {4'd9,  K_RD,  3'd5, 32'h60},   // R9
      {4'd9,  K_RD,  3'd6, 32'h10},   // R9
      {4'd6,  K_WR,  3'd1, 32'hF},    // R6 all sources
      {4'd5,  K_ERR, 3'd0, 32'h1},    // R5 parity
      {4'd6,  K_RX,  3'd0, 32'h5A},   // R6
      {4'd6,  K_MDM, 3'd0, 32'h01},   // R6
      {4'd6,  K_RD,  3'd2, 32'h6},    // R6
      {4'd5,  K_RD,  3'd5, 32'h65},   // R5
      {4'd6,  K_RD,  3'd2, 32'h4},    // R6
      {4'd3,  K_RD,  3'd0, 32'h5A},   // R3
      {4'd6,  K_RD,  3'd2, 32'h2},    // R6
      {4'd5,  K_ERR, 3'd0, 32'h2},    // R5 frame
      {4'd5,  K_RD,  3'd5, 32'h68},   // R5
      {4'd5,  K_ERR, 3'd0, 32'h4}     // R5 break, read back in directed part
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_sel = 1'b0, bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [BUS_W-1:0]  bus_wdata = '0;
   logic [BUS_W-1:0]  bus_rdata;
   logic              rx_valid = 1'b0;
   logic [7:0]        rx_byte = '0;
   logic              rx_ready;
   logic              err_parity = 1'b0, err_frame = 1'b0, err_break = 1'b0;
   logic [7:0]        modem_in = '0;
   logic              tx_valid;
   logic [7:0]        tx_byte;
   logic [3:0]        ier_out;
   logic [7:0]        line_ctrl, modem_ctrl;
   logic [DIV_W-1:0]  divisor;
   logic              irq;

   int tests = 0;
   int fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_regbank u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
      .err_parity(err_parity), .err_frame(err_frame), .err_break(err_break),
      .modem_in(modem_in), .tx_valid(tx_valid), .tx_byte(tx_byte),
      .ier_out(ier_out), .line_ctrl(line_ctrl), .modem_ctrl(modem_ctrl),
      .divisor(divisor), .irq(irq)
   );

   task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] ofs, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = {ofs, 2'b00}; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] ofs, input logic [31:0] exp, input int req);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = {ofs, 2'b00};
      #1 check(req, bus_rdata, exp, $sformatf("read offset %0d", ofs));
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic pulse_rx(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1; rx_byte = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   task automatic pulse_err(input logic [2:0] m);
      @(negedge clk);
      {err_break, err_frame, err_parity} = m;
      @(negedge clk);
      {err_break, err_frame, err_parity} = 3'b000;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      @(negedge clk);
      check(1, {31'b0, irq}, 32'h0, "irq after reset");
      check(1, {31'b0, rx_ready}, 32'h1, "rx_ready after reset");
      check(1, {31'b0, tx_valid}, 32'h0, "tx_valid after reset");
      check(1, {8'b0, line_ctrl, modem_ctrl, divisor[7:0]}, 32'h0, "control outputs after reset");
      bus_read(3'd5, 32'h60, 1);
      bus_read(3'd2, 32'h1, 1);

      // vector table
      for (int i = 0; i < NV; i++) begin
         automatic int          rq = int'(VEC[i][41:38]);
         automatic logic [2:0]  k  = VEC[i][37:35];
         automatic logic [2:0]  o  = VEC[i][34:32];
         automatic logic [31:0] d  = VEC[i][31:0];
         case (k)
            K_WR:  bus_write(o, d);
            K_RD:  bus_read(o, d, rq);
            K_RX:  pulse_rx(d[7:0]);
            K_ERR: pulse_err(d[2:0]);
            K_MDM: begin
               @(negedge clk); modem_in = d[7:0];
               @(negedge clk);
            end
            default: begin
               @(negedge clk);
               check(rq, {31'b0, irq}, d, "irq level");
            end
         endcase
      end

      // R5 break bit, then strobe in the same cycle as a status read
      bus_read(3'd5, 32'h70, 5);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = {3'd5, 2'b00}; err_parity = 1'b1;
      #1 check(5, bus_rdata, 32'h60, "status read with strobe");
      @(negedge clk);
      bus_sel = 1'b0; err_parity = 1'b0;
      bus_read(3'd5, 32'h64, 5);
      bus_read(3'd5, 32'h60, 5);

      // R2 ready handshake, R3 read and arrival in the same cycle
      pulse_rx(8'hA1);
      check(2, {31'b0, rx_ready}, 32'h0, "rx_ready with byte held");
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'd0; rx_valid = 1'b1; rx_byte = 8'hB2;
      #1 check(3, bus_rdata, 32'hA1, "data read during arrival");
      @(negedge clk);
      bus_sel = 1'b0; rx_valid = 1'b0;
      bus_read(3'd5, 32'h61, 3);
      bus_read(3'd0, 32'hB2, 3);
      check(2, {31'b0, rx_ready}, 32'h1, "rx_ready after read");

      // R10 transmit stream
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 5'd0; bus_wdata = 32'h1234_56C3;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      check(10, {23'b0, tx_valid, tx_byte}, 32'h1C3, "tx pulse");
      @(negedge clk);
      check(10, {31'b0, tx_valid}, 32'h0, "tx pulse ends");

      // R8 control outputs
      bus_write(3'd3, 32'h1B);
      bus_write(3'd4, 32'h3);
      bus_write(3'd7, 32'h0145);
      bus_write(3'd1, 32'hA);
      check(8, {8'b0, line_ctrl, modem_ctrl, 8'b0}, 32'h001B_0300, "line/modem control");
      check(8, {16'b0, divisor}, 32'h0145, "divisor");
      check(8, {28'b0, ier_out}, 32'hA, "enables");
      bus_read(3'd3, 32'h0, 8);
      bus_read(3'd7, 32'h0, 8);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule